// File: doc/BRIEF.md
# Floating-Point Special-Operand Exception Detector

This block sits next to a single-precision arithmetic unit that performs add, subtract, multiply, divide, four fused multiply-add variants and reciprocal square root. For each issued operation it receives the opcode, the raw operand words (up to three), the numeric result the arithmetic datapath produced for that operation, and two trap-enable bits. It classifies every operand after flushing denormals to zero. From the operand classes it decides whether the operation is an invalid operation or a division by zero.

When a trap is enabled, the detector reports the matching cause and suppresses the register write. When no trap is enabled, it substitutes the default result: a quiet NaN, a signed zero or a signed infinity. In every other case the numeric result passes through untouched. The verdict is registered, so it appears one cycle after the issue strobe. Operations can be issued on back-to-back cycles.

Top module: `fpx_special_detect`

## Requirements
- R1: While reset is held and in every cycle where `out_valid` is low, `out_valid`, `out_write`, `out_cause_inv` and `out_cause_dz` are 0.
- R2: `out_valid` is high in the cycle after each cycle where `in_valid` is high, and low otherwise. Issues on back-to-back cycles produce back-to-back verdicts in issue order.
- R3: An operand is a signalling NaN when its exponent is all ones, its fraction is nonzero and the fraction MSB is 0. Any signalling NaN among the operands an opcode reads makes the operation invalid. This applies to every opcode.
- R4: Opcode 0 (a+b) is invalid when both operands are infinite with opposite signs. Opcode 1 (a-b) is invalid when both are infinite with equal signs.
- R5: Opcode 2 (a*b) is invalid for infinity times zero in either order. Opcode 3 (a/b) is invalid for infinity over infinity and for zero over zero.
- R6: The fused opcodes compute 4: a*b+c, 5: a*b-c, 6: -(a*b)+c, 7: -(a*b)-c. Each is invalid when a*b is infinity times zero. Each is also invalid when a*b is infinite, c is infinite, and the two cancel. Cancelling means opposite signs for 4 and 7, and equal signs for 5 and 6.
- R7: For an invalid operation with `en_inv`=1, `out_cause_inv`=1 and `out_write`=0. With `en_inv`=0, `out_write`=1 and `out_result`=0x7FC00000. Invalid takes priority over divide-by-zero. Whenever `out_write`=0, `out_result` is 0.
- R8: Opcode 3 with a nonzero finite dividend and a zero divisor is a divide-by-zero. With `en_dz`=1, `out_cause_dz`=1 and `out_write`=0. With `en_dz`=0, the result written is an infinity whose sign is the XOR of the operand signs.
- R9: Opcode 8 (reciprocal square root of a) treats a negative nonzero finite value or -infinity as invalid. A quiet NaN yields 0x7FC00000. +infinity yields +0. A zero of either sign is a divide-by-zero whose default result is an infinity of that sign.
- R10: An operand with a zero exponent field and a nonzero fraction is treated as a zero of the same sign in every rule above.
- R11: When no rule above applies, `out_write`=1, both causes are 0, and `out_result` equals the `num_result` presented with the issue.
- R12: Operands an opcode does not read are ignored: c for opcodes 0-3, b and c for opcode 8. Opcodes 9-15 read no operand and always follow R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Issue strobe |
| in_op | input | 4 | Opcode (0-8 defined, 9-15 pass-through) |
| in_a | input | 32 | Operand a, raw single-precision word |
| in_b | input | 32 | Operand b |
| in_c | input | 32 | Operand c (fused forms only) |
| num_result | input | 32 | Result computed by the arithmetic datapath |
| en_inv | input | 1 | Trap enable for invalid operation |
| en_dz | input | 1 | Trap enable for divide-by-zero |
| out_valid | output | 1 | Verdict valid, one cycle after issue |
| out_write | output | 1 | Destination register is to be written |
| out_result | output | 32 | Value to write |
| out_cause_inv | output | 1 | Invalid-operation cause |
| out_cause_dz | output | 1 | Divide-by-zero cause |

## Verification
The cases hardest to reach are those where a denormal operand must change the verdict. Examples are infinity times a denormal becoming invalid, and a denormal divisor becoming a trapped divide-by-zero. Random words almost never hit the all-ones or all-zero exponent needed to reach them. The stimulus therefore builds operand words directly from a small set of encodings: signed zeros, denormals, normals, infinities, quiet and signalling NaNs. It then drives each opcode with the exact combinations that sit on either side of a rule, including the fused cancel and no-cancel sign pairs. It also issues a signalling NaN in an operand slot that the opcode does not read.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

    // Opcode encoding seen on in_op
    localparam logic [3:0] OP_ADD   = 4'd0;
    localparam logic [3:0] OP_SUB   = 4'd1;
    localparam logic [3:0] OP_MUL   = 4'd2;
    localparam logic [3:0] OP_DIV   = 4'd3;
    localparam logic [3:0] OP_MADD  = 4'd4;
    localparam logic [3:0] OP_MSUB  = 4'd5;
    localparam logic [3:0] OP_NMADD = 4'd6;
    localparam logic [3:0] OP_NMSUB = 4'd7;
    localparam logic [3:0] OP_RSQRT = 4'd8;

    // Operand class after denormal flush
    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_NORM = 3'd1,
        CLS_INF  = 3'd2,
        CLS_QNAN = 3'd3,
        CLS_SNAN = 3'd4
    } fpx_cls_e;

    typedef struct packed {
        fpx_cls_e cls;
        logic     sign;
    } fpx_opnd_t;

    // Which value the destination receives
    typedef enum logic [1:0] {
        RES_NUM  = 2'd0,
        RES_QNAN = 2'd1,
        RES_ZERO = 2'd2,
        RES_INF  = 2'd3
    } fpx_res_e;

    typedef struct packed {
        logic     write;
        logic     c_inv;
        logic     c_dz;
        fpx_res_e kind;
        logic     sign;
    } fpx_verdict_t;

endpackage

// File: rtl/fpx_operand_class.sv
// Operand classifier.
// Splits a raw IEEE-style word into sign, exponent and fraction and reports
// one of zero / normal / infinity / quiet NaN / signalling NaN.
// Assumes: the quiet bit is the fraction MSB; denormals are flushed to zero
// (they report CLS_ZERO with their own sign).
module fpx_operand_class #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] word_i,
    output fpx_pkg::fpx_opnd_t    info_o
);
    import fpx_pkg::*;

    localparam int WORD_W = 1 + EXP_W + FRAC_W;

    logic [EXP_W-1:0]  expf;
    logic [FRAC_W-1:0] frac;

    assign expf = word_i[WORD_W-2 -: EXP_W];
    assign frac = word_i[FRAC_W-1:0];

    // Decode the class from the exponent and fraction fields
    always_comb begin
        info_o.sign = word_i[WORD_W-1];
        if (&expf) begin
            if (frac == '0)
                info_o.cls = CLS_INF;
            else if (frac[FRAC_W-1])
                info_o.cls = CLS_QNAN;
            else
                info_o.cls = CLS_SNAN;
        end else if (expf == '0) begin
            info_o.cls = CLS_ZERO;
        end else begin
            info_o.cls = CLS_NORM;
        end
    end

endmodule

// File: rtl/fpx_verdict.sv
// Exception rule engine.
// From the opcode, the three operand classes and the two trap enables,
// decides invalid / divide-by-zero / special default / pass-through.
// Assumes: operand classes already flushed; opcodes 9-15 read nothing.
module fpx_verdict (
    input  logic [3:0]             op_i,
    input  fpx_pkg::fpx_opnd_t     a_i,
    input  fpx_pkg::fpx_opnd_t     b_i,
    input  fpx_pkg::fpx_opnd_t     c_i,
    input  logic                   en_inv_i,
    input  logic                   en_dz_i,
    output fpx_pkg::fpx_verdict_t  verdict_o
);
    import fpx_pkg::*;

    logic is_bin, is_fused, is_rsqrt;
    logic snan_a, snan_b, snan_c, any_snan;
    logic a_inf, b_inf, c_inf, a_zero, b_zero, a_norm, b_norm;
    logic prod_inf_zero, prod_inf, prod_sign, cancel, fused_bad;
    logic invalid, div_zero;
    logic rs_qnan, rs_pinf;

    // Opcode grouping
    always_comb begin
        is_bin   = (op_i <= OP_DIV);
        is_fused = (op_i >= OP_MADD) && (op_i <= OP_NMSUB);
        is_rsqrt = (op_i == OP_RSQRT);
    end

    // Per-operand class flags
    always_comb begin
        snan_a = (a_i.cls == CLS_SNAN);
        snan_b = (b_i.cls == CLS_SNAN);
        snan_c = (c_i.cls == CLS_SNAN);
        a_inf  = (a_i.cls == CLS_INF);
        b_inf  = (b_i.cls == CLS_INF);
        c_inf  = (c_i.cls == CLS_INF);
        a_zero = (a_i.cls == CLS_ZERO);
        b_zero = (b_i.cls == CLS_ZERO);
        a_norm = (a_i.cls == CLS_NORM);
        b_norm = (b_i.cls == CLS_NORM);
    end

    // Signalling NaN only counts in operands the opcode reads
    always_comb begin
        any_snan = 1'b0;
        if (is_bin)        any_snan = snan_a | snan_b;
        else if (is_fused) any_snan = snan_a | snan_b | snan_c;
        else if (is_rsqrt) any_snan = snan_a;
    end

    // Product behaviour of the fused forms and the cancel test on the addend
    always_comb begin
        prod_inf_zero = (a_inf & b_zero) | (a_zero & b_inf);
        prod_inf      = (a_inf & b_inf) | (a_inf & b_norm) | (a_norm & b_inf);
        prod_sign     = a_i.sign ^ b_i.sign;
        case (op_i)
            OP_MADD, OP_NMSUB: cancel = (prod_sign != c_i.sign);
            OP_MSUB, OP_NMADD: cancel = (prod_sign == c_i.sign);
            default:           cancel = 1'b0;
        endcase
        fused_bad = prod_inf_zero | (prod_inf & c_inf & cancel);
    end

    // Invalid-operation and divide-by-zero detection per opcode
    always_comb begin
        invalid  = any_snan;
        div_zero = 1'b0;
        case (op_i)
            OP_ADD: invalid = invalid | (a_inf & b_inf & (a_i.sign != b_i.sign));
            OP_SUB: invalid = invalid | (a_inf & b_inf & (a_i.sign == b_i.sign));
            OP_MUL: invalid = invalid | prod_inf_zero;
            OP_DIV: begin
                invalid  = invalid | (a_inf & b_inf) | (a_zero & b_zero);
                div_zero = a_norm & b_zero;
            end
            OP_MADD, OP_MSUB, OP_NMADD, OP_NMSUB:
                invalid = invalid | fused_bad;
            OP_RSQRT: begin
                invalid  = invalid | (a_i.sign & (a_norm | a_inf));
                div_zero = a_zero;
            end
            default: invalid = 1'b0;
        endcase
    end

    // Reciprocal square root special defaults
    always_comb begin
        rs_qnan = is_rsqrt & (a_i.cls == CLS_QNAN);
        rs_pinf = is_rsqrt & a_inf & ~a_i.sign;
    end

    // Resolve priority: invalid, then divide-by-zero, then special default
    always_comb begin
        verdict_o.write = 1'b1;
        verdict_o.c_inv = 1'b0;
        verdict_o.c_dz  = 1'b0;
        verdict_o.kind  = RES_NUM;
        verdict_o.sign  = 1'b0;
        if (invalid) begin
            verdict_o.c_inv = en_inv_i;
            verdict_o.write = ~en_inv_i;
            verdict_o.kind  = RES_QNAN;
        end else if (div_zero) begin
            verdict_o.c_dz  = en_dz_i;
            verdict_o.write = ~en_dz_i;
            verdict_o.kind  = RES_INF;
            verdict_o.sign  = is_rsqrt ? a_i.sign : prod_sign;
        end else if (rs_qnan) begin
            verdict_o.kind  = RES_QNAN;
        end else if (rs_pinf) begin
            verdict_o.kind  = RES_ZERO;
        end
    end

    // R7: a trap never coexists with a write
    always_comb begin
        a_r7_trap_no_write: assert (!((verdict_o.c_inv | verdict_o.c_dz) & verdict_o.write));
    end

endmodule

// File: rtl/fpx_result_form.sv
// Result former.
// Builds the word to write from the verdict: the datapath result, the
// default quiet NaN, or a signed zero / infinity. Drives zero when no
// write is to happen.
// Assumes: default quiet NaN is positive with only the quiet bit set.
module fpx_result_form #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  fpx_pkg::fpx_verdict_t  verdict_i,
    input  logic [EXP_W+FRAC_W:0]  num_i,
    output logic [EXP_W+FRAC_W:0]  word_o
);
    import fpx_pkg::*;

    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam logic [FRAC_W-1:0] QUIET_FRAC = {1'b1, {(FRAC_W-1){1'b0}}};

    // Select the written value
    always_comb begin
        if (!verdict_i.write) begin
            word_o = '0;
        end else begin
            case (verdict_i.kind)
                RES_QNAN: word_o = {1'b0, {EXP_W{1'b1}}, QUIET_FRAC};
                RES_ZERO: word_o = {verdict_i.sign, {(WORD_W-1){1'b0}}};
                RES_INF:  word_o = {verdict_i.sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
                default:  word_o = num_i;
            endcase
        end
    end

endmodule

// File: rtl/fpx_special_detect.sv
// Special-operand exception detector, top level.
// Classifies up to three operands, applies the per-opcode exception rules,
// forms the result word and registers everything behind in_valid.
// Assumes: num_result belongs to the operation issued in the same cycle.
module fpx_special_detect #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [3:0]              in_op,
    input  logic [EXP_W+FRAC_W:0]   in_a,
    input  logic [EXP_W+FRAC_W:0]   in_b,
    input  logic [EXP_W+FRAC_W:0]   in_c,
    input  logic [EXP_W+FRAC_W:0]   num_result,
    input  logic                    en_inv,
    input  logic                    en_dz,
    output logic                    out_valid,
    output logic                    out_write,
    output logic [EXP_W+FRAC_W:0]   out_result,
    output logic                    out_cause_inv,
    output logic                    out_cause_dz
);
    import fpx_pkg::*;

    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int N_OPND = 3;
    localparam logic [WORD_W-1:0] QNAN_WORD =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic [N_OPND-1:0][WORD_W-1:0] opnd_word;
    fpx_opnd_t                     opnd_info [N_OPND];
    fpx_verdict_t                  verdict;
    logic [WORD_W-1:0]             word_next;

    assign opnd_word = {in_c, in_b, in_a};

    // One classifier per operand slot
    for (genvar gi = 0; gi < N_OPND; gi++) begin : g_cls
        fpx_operand_class #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .word_i (opnd_word[gi]),
            .info_o (opnd_info[gi])
        );
    end

    fpx_verdict u_rules (
        .op_i      (in_op),
        .a_i       (opnd_info[0]),
        .b_i       (opnd_info[1]),
        .c_i       (opnd_info[2]),
        .en_inv_i  (en_inv),
        .en_dz_i   (en_dz),
        .verdict_o (verdict)
    );

    fpx_result_form #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_form (
        .verdict_i (verdict),
        .num_i     (num_result),
        .word_o    (word_next)
    );

    // Output register stage, cleared on reset and on idle cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_write     <= 1'b0;
            out_result    <= '0;
            out_cause_inv <= 1'b0;
            out_cause_dz  <= 1'b0;
        end else begin
            out_valid     <= in_valid;
            out_write     <= in_valid & verdict.write;
            out_result    <= in_valid ? word_next : '0;
            out_cause_inv <= in_valid & verdict.c_inv;
            out_cause_dz  <= in_valid & verdict.c_dz;
        end
    end

    // Signals used by the assertions below
    logic a_snan_seen, all_plain;
    always_comb begin
        a_snan_seen = (in_op <= OP_RSQRT) && (opnd_info[0].cls == CLS_SNAN);
        all_plain   = (in_op <= OP_NMSUB) && (opnd_info[0].cls == CLS_NORM)
                   && (opnd_info[1].cls == CLS_NORM) && (opnd_info[2].cls == CLS_NORM);
    end

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_write && !out_cause_inv && !out_cause_dz));
    a_r7_trap_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        (out_cause_inv || out_cause_dz) |-> (!out_write && out_result == '0));
    a_r3_snan_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && a_snan_seen) |=> (out_cause_inv || (out_write && out_result == QNAN_WORD)));
    a_r11_plain_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && all_plain) |=> (out_write && out_result == $past(num_result)));

endmodule

// File: tb/fpx_special_detect_tb.sv
`timescale 1ns/1ps
module fpx_special_detect_tb;

    localparam logic [31:0] PZ   = 32'h0000_0000;
    localparam logic [31:0] NZ   = 32'h8000_0000;
    localparam logic [31:0] PINF = 32'h7F80_0000;
    localparam logic [31:0] NINF = 32'hFF80_0000;
    localparam logic [31:0] QN   = 32'h7FC0_0000;
    localparam logic [31:0] SN   = 32'h7F80_0001;
    localparam logic [31:0] ONE  = 32'h3F80_0000;
    localparam logic [31:0] NONE = 32'hBF80_0000;
    localparam logic [31:0] TWO  = 32'h4000_0000;
    localparam logic [31:0] DEN  = 32'h0000_0001;
    localparam logic [31:0] NDEN = 32'h8000_0001;
    localparam logic [31:0] NUMV = 32'h1357_2468;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_op = '0;
    logic [31:0] in_a = '0, in_b = '0, in_c = '0, num_result = '0;
    logic        en_inv = 1'b0, en_dz = 1'b0;
    logic        out_valid, out_write, out_cause_inv, out_cause_dz;
    logic [31:0] out_result;

    int checks = 0;
    int errors = 0;
    logic [34:0] exp_q [$];
    string       tag_q [$];

    always #2.5 clk = ~clk;

    fpx_special_detect u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_a(in_a), .in_b(in_b), .in_c(in_c), .num_result(num_result),
        .en_inv(en_inv), .en_dz(en_dz), .out_valid(out_valid),
        .out_write(out_write), .out_result(out_result),
        .out_cause_inv(out_cause_inv), .out_cause_dz(out_cause_dz)
    );

    // Driver: issue one operation and queue its expected verdict
    task automatic send(input logic [3:0] op, input logic [31:0] a, b, c,
                        input logic ev, ez, ewr, input logic [31:0] eres,
                        input logic ecv, ecz, input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_c = c;
        num_result = NUMV; en_inv = ev; en_dz = ez;
        exp_q.push_back({ewr, ewr ? eres : 32'h0, ecv, ecz});
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        in_a = SN; in_b = SN; in_c = SN;
    endtask

    // Monitor: compare each verdict against the queue head
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R2: unexpected out_valid, got 1 expected 0");
            end else begin
                logic [34:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({out_write, out_result, out_cause_inv, out_cause_dz} !== e) begin
                    errors++;
                    $display("FAIL %s: got wr=%b res=%h cv=%b cz=%b expected wr=%b res=%h cv=%b cz=%b",
                             t, out_write, out_result, out_cause_inv, out_cause_dz,
                             e[34], e[33:2], e[1], e[0]);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R2: watchdog expired, got hang expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        checks++;
        if ({out_valid, out_write, out_cause_inv, out_cause_dz} !== 4'b0) begin
            errors++;
            $display("FAIL R1: reset outputs got %b expected 0000",
                     {out_valid, out_write, out_cause_inv, out_cause_dz});
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R11 plain pass-through
        send(4'd0, ONE, TWO, SN, 0, 0, 1, NUMV, 0, 0, "R11 add normals");
        // R4 add / sub infinity rules (back-to-back, R2)
        send(4'd0, PINF, NINF, PZ, 0, 0, 1, QN,   0, 0, "R4 add opposite inf");
        send(4'd0, PINF, NINF, PZ, 1, 0, 0, 0,    1, 0, "R7 add opposite inf trap");
        send(4'd0, PINF, PINF, PZ, 0, 0, 1, NUMV, 0, 0, "R4 add same inf ok");
        send(4'd1, PINF, PINF, PZ, 0, 0, 1, QN,   0, 0, "R4 sub same inf");
        send(4'd1, PINF, NINF, PZ, 0, 0, 1, NUMV, 0, 0, "R4 sub opposite inf ok");
        // R5 multiply / divide
        send(4'd2, NINF, PZ,  PZ, 0, 0, 1, QN,   0, 0, "R5 mul inf*0");
        send(4'd2, PZ,  PINF, PZ, 1, 1, 0, 0,    1, 0, "R5 mul 0*inf trap");
        send(4'd3, PINF, NINF, PZ, 0, 0, 1, QN,  0, 0, "R5 div inf/inf");
        send(4'd3, PZ,  NZ,   PZ, 0, 1, 1, QN,   0, 0, "R7 div 0/0 invalid over dz");
        send(4'd3, PZ,  PINF, PZ, 0, 0, 1, NUMV, 0, 0, "R11 div 0/inf");
        // R8 divide by zero
        send(4'd3, ONE, PZ,  PZ, 0, 1, 0, 0,    0, 1, "R8 div x/0 trap");
        send(4'd3, NONE, PZ, PZ, 0, 0, 1, NINF, 0, 0, "R8 div -x/+0 default");
        send(4'd3, NONE, NZ, PZ, 0, 0, 1, PINF, 0, 0, "R8 div -x/-0 default");
        // R10 denormal flush
        send(4'd2, PINF, DEN, PZ, 0, 0, 1, QN,  0, 0, "R10 mul inf*denormal");
        send(4'd3, TWO, NDEN, PZ, 1, 1, 0, 0,   0, 1, "R10 div by denormal trap");
        // R3 signalling NaN
        send(4'd2, ONE, SN,  PZ, 1, 0, 0, 0,    1, 0, "R3 mul snan in b");
        send(4'd4, ONE, ONE, SN, 0, 0, 1, QN,   0, 0, "R3 madd snan in c");
        send(4'd0, QN,  ONE, PZ, 0, 0, 1, NUMV, 0, 0, "R11 add qnan passes");
        // R12 unread operand
        send(4'd0, ONE, ONE, SN, 1, 1, 1, NUMV, 0, 0, "R12 add ignores c");
        // R6 fused cancel rules
        send(4'd4, PINF, ONE,  NINF, 0, 0, 1, QN,   0, 0, "R6 madd cancel");
        send(4'd4, PINF, ONE,  PINF, 0, 0, 1, NUMV, 0, 0, "R6 madd no cancel");
        send(4'd5, PINF, ONE,  PINF, 0, 0, 1, QN,   0, 0, "R6 msub cancel");
        send(4'd5, PINF, ONE,  NINF, 0, 0, 1, NUMV, 0, 0, "R6 msub no cancel");
        send(4'd6, PINF, NONE, NINF, 1, 0, 0, 0,    1, 0, "R6 nmadd cancel trap");
        send(4'd6, PINF, ONE,  NINF, 0, 0, 1, NUMV, 0, 0, "R6 nmadd no cancel");
        send(4'd7, PINF, ONE,  NINF, 0, 0, 1, QN,   0, 0, "R6 nmsub cancel");
        send(4'd7, PINF, ONE,  PINF, 0, 0, 1, NUMV, 0, 0, "R6 nmsub no cancel");
        send(4'd4, PINF, PZ,   ONE,  0, 0, 1, QN,   0, 0, "R6 madd inf*0 product");
        send(4'd4, QN,   PINF, NINF, 0, 0, 1, NUMV, 0, 0, "R6 madd nan product not inf");
        // R9 reciprocal square root
        send(4'd8, NONE, PZ, PZ, 0, 0, 1, QN,   0, 0, "R9 rsqrt negative");
        send(4'd8, NINF, PZ, PZ, 1, 0, 0, 0,    1, 0, "R9 rsqrt -inf trap");
        send(4'd8, QN,   PZ, PZ, 0, 0, 1, QN,   0, 0, "R9 rsqrt qnan");
        send(4'd8, PINF, PZ, PZ, 0, 0, 1, PZ,   0, 0, "R9 rsqrt +inf");
        send(4'd8, NZ,   PZ, PZ, 0, 0, 1, NINF, 0, 0, "R9 rsqrt -0");
        send(4'd8, PZ,   PZ, PZ, 0, 1, 0, 0,    0, 1, "R9 rsqrt +0 trap");
        send(4'd8, NDEN, PZ, PZ, 0, 0, 1, NINF, 0, 0, "R10 rsqrt -denormal");
        send(4'd8, SN,   PZ, PZ, 1, 0, 0, 0,    1, 0, "R3 rsqrt snan");
        send(4'd8, TWO,  SN, SN, 1, 1, 1, NUMV, 0, 0, "R12 rsqrt ignores b c");
        send(4'd9, SN,   SN, SN, 1, 1, 1, NUMV, 0, 0, "R12 reserved opcode");
        send(4'd15, PINF, PZ, NINF, 0, 0, 1, NUMV, 0, 0, "R12 reserved opcode 15");

        idle();
        repeat (3) @(negedge clk);
        // R2: verdicts drained, no stray valid
        checks++;
        if (exp_q.size() != 0 || out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R2: pending=%0d out_valid=%b expected 0 0", exp_q.size(), out_valid);
        end
        // R1: idle outputs quiet
        checks++;
        if ({out_write, out_cause_inv, out_cause_dz} !== 3'b0) begin
            errors++;
            $display("FAIL R1: idle outputs got %b expected 000",
                     {out_write, out_cause_inv, out_cause_dz});
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule